// File: doc/BRIEF.md
# Page-Buffered Flash Write Sequencer

This block models the write path of a byte-wide flash memory that is written one page at a time. A host drives active-low chip-enable, output-enable and write-enable lines, an address and a data byte. The block samples these lines on a system clock. Each completed write strobe loads one byte into a page buffer. A page holds 2^PAGE_BITS bytes, 256 by default. The load phase stays open while bytes keep arriving. It closes by itself once no byte has arrived for `LOAD_WIN` clock edges. A timed internal program cycle of `PROG_CYC` clock edges then follows. At its end the whole page in the behavioural storage array is replaced. Bytes that were not loaded become all-ones.

While the program cycle runs, reads do not return array contents. They return a status byte: bit 7 is the complement of bit 7 of the last loaded byte, bit 6 flips on every new read access, and bits 5:0 are the low bits of the last loaded byte. Polling software uses this status to find the end of the cycle. The sequencer has three states:

- `ST_IDLE`: waiting for a first load. A load moves it to `ST_LOAD`.
- `ST_LOAD`: page buffer open. A load to the same page stays in `ST_LOAD` and restarts the window. The window expiring moves it to `ST_PROG`.
- `ST_PROG`: internal program cycle. It returns to `ST_IDLE` when the page is committed.

Top module: `pgf_writer`

## Requirements
- R1: A load happens only when a strobe with `ce_n`=0, `we_n`=0 and `oe_n`=1 ends because `ce_n` or `we_n` rises. A strobe that ends because `oe_n` falls loads nothing. With `oe_n` low, no strobe starts.
- R2: The load address is taken on the first clock edge of the strobe. The load data is the value of `din` on the last clock edge of the strobe. The address and data in between are ignored.
- R3: `addr[ADDR_W-1:PAGE_BITS]` selects the page and `addr[PAGE_BITS-1:0]` selects the byte within it.
- R4: While `ST_LOAD` is open, a load naming another page is ignored. It also sets `page_err`, which stays at 1 until reset.
- R5: Bytes may be loaded in any order. A second load to the same byte in one load phase replaces the earlier value.
- R6: `ST_LOAD` moves to `ST_PROG` on the `LOAD_WIN`-th clock edge after the last accepted load, if no accepted load arrives on that edge or on any edge before it.
- R7: On the `PROG_CYC`-th edge in `ST_PROG`, every byte of the page is written: loaded bytes get their value and unloaded bytes get 0xFF. Loads arriving during `ST_PROG` are ignored.
- R8: A read sampled in `ST_PROG` returns bit 7 as the complement of bit 7 of the last loaded byte, and bits 5:0 equal to its bits 5:0.
- R9: In `ST_PROG`, bit 6 of the status is 1 on the first read access and flips on each new access. It holds steady while one access is held.
- R10: A read is sampled when `ce_n`=0, `oe_n`=0 and `we_n`=1. One clock later, `dout_en`=1 and `dout` shows the byte. Otherwise `dout_en`=0 and `dout`=0x00.
- R11: After reset the state is `ST_IDLE`, every array byte reads 0xFF, `page_err`=0 and `dout_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from host |
| dout | output | DATA_W | Read data or status, 0 when not driven |
| dout_en | output | 1 | Read data valid (stands for bus driven) |
| page_err | output | 1 | Sticky flag: load to a foreign page was refused |

## Verification
A load takes effect one edge after its strobe ends. Read data appears one edge after the read is sampled. The page commit lands `LOAD_WIN` edges after the last accepted load, plus `PROG_CYC` edges. The bench keeps a behavioural model that it advances on each rising edge from the same sampled inputs. It compares `dout`, `dout_en` and `page_err` on every falling edge, where every registered result has settled. Directed reads add fixed expected bytes for out-of-order loads, overwrites, erased fill, refused loads, inhibited strobes and the status bits.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pgf_bus_sync.sv
module pgf_bus_sync #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              ld_go,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic              rd_on,
    output logic              rd_new
);
    logic wr_act, wr_act_q, rd_q;
    logic [ADDR_W-1:0] a_lat;
    logic [DATA_W-1:0] d_lat;

    assign wr_act  = ~ce_n & ~we_n & oe_n;
    assign rd_on   = ~ce_n & ~oe_n & we_n;
    assign rd_new  = rd_on & ~rd_q;
    // strobe closed by ce_n/we_n rising (oe_n still high) -> load
    assign ld_go   = wr_act_q & ~wr_act & oe_n;
    assign ld_addr = a_lat;
    assign ld_data = d_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_q     <= 1'b0;
            a_lat    <= '0;
            d_lat    <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_q     <= rd_on;
            if (wr_act && !wr_act_q) a_lat <= addr;
            if (wr_act)              d_lat <= din;
        end
    end

    // R2: address frozen for the rest of a strobe
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act_q && wr_act) |=> $stable(a_lat));
endmodule

// File: rtl/pgf_store.sv
module pgf_store #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 8,
    localparam int DEPTH      = 1 << ADDR_W,
    localparam int PAGE_BYTES = 1 << PAGE_BITS,
    localparam int PG_W       = ADDR_W - PAGE_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [DATA_W-1:0]            rdata,
    input  logic                         pg_go,
    input  logic [PG_W-1:0]              pg_sel,
    input  logic [PAGE_BYTES*DATA_W-1:0] pg_bytes,
    input  logic [PAGE_BYTES-1:0]        pg_valid
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= {DATA_W{1'b1}};
        end else if (pg_go) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pg_valid[i])
                    mem[{pg_sel, PAGE_BITS'(i)}] <= pg_bytes[i*DATA_W +: DATA_W];
                else
                    mem[{pg_sel, PAGE_BITS'(i)}] <= {DATA_W{1'b1}};
            end
        end
    end
endmodule

// File: rtl/pgf_seq.sv
module pgf_seq
    import pgf_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 8,
    parameter int LOAD_WIN  = 20,
    parameter int PROG_CYC  = 60,
    localparam int PAGE_BYTES = 1 << PAGE_BITS,
    localparam int PG_W       = ADDR_W - PAGE_BITS,
    localparam int CNT_MAX    = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC,
    localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_go,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [DATA_W-1:0]            ld_data,
    input  logic                         rd_on,
    input  logic                         rd_new,
    input  logic [DATA_W-1:0]            rdata,
    output logic                         pg_go,
    output logic [PG_W-1:0]              pg_sel,
    output logic [PAGE_BYTES*DATA_W-1:0] pg_bytes,
    output logic [PAGE_BYTES-1:0]        pg_valid,
    output logic [DATA_W-1:0]            dout,
    output logic                         dout_en,
    output logic                         page_err
);
    seq_state_e st, st_nx;
    logic [CNT_W-1:0]      cnt;
    logic [DATA_W-1:0]     pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;
    logic [PG_W-1:0]       pg_q;
    logic [DATA_W-1:0]     last_q;
    logic                  tog;
    logic                  same_pg, win_end, prog_end, tog_nx;
    logic [PAGE_BITS-1:0]  byte_ix;

    assign byte_ix  = ld_addr[PAGE_BITS-1:0];
    assign same_pg  = (ld_addr[ADDR_W-1:PAGE_BITS] == pg_q);
    assign win_end  = (cnt == CNT_W'(LOAD_WIN - 1));
    assign prog_end = (cnt == CNT_W'(PROG_CYC - 1));
    assign tog_nx   = rd_new ? ~tog : tog;
    assign pg_go    = (st == ST_PROG) && prog_end;
    assign pg_sel   = pg_q;
    assign pg_valid = valid_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pack
        assign pg_bytes[g*DATA_W +: DATA_W] = pbuf[g];
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (ld_go) st_nx = ST_LOAD;
            ST_LOAD: if (!(ld_go && same_pg) && win_end) st_nx = ST_PROG;
            ST_PROG: if (prog_end) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            valid_q  <= '0;
            pg_q     <= '0;
            last_q   <= '0;
            tog      <= 1'b0;
            page_err <= 1'b0;
            dout     <= '0;
            dout_en  <= 1'b0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (ld_go) begin
                        valid_q       <= '0;
                        valid_q[byte_ix] <= 1'b1;
                        pbuf[byte_ix] <= ld_data;
                        pg_q          <= ld_addr[ADDR_W-1:PAGE_BITS];
                        last_q        <= ld_data;
                    end
                end
                ST_LOAD: begin
                    if (ld_go && !same_pg) page_err <= 1'b1;
                    if (ld_go && same_pg) begin
                        cnt              <= '0;
                        valid_q[byte_ix] <= 1'b1;
                        pbuf[byte_ix]    <= ld_data;
                        last_q           <= ld_data;
                    end else if (win_end) begin
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: cnt <= prog_end ? '0 : cnt + 1'b1;
                default: cnt <= '0;
            endcase

            tog     <= (st == ST_PROG) ? tog_nx : 1'b0;
            dout_en <= rd_on;
            if (!rd_on)
                dout <= '0;
            else if (st == ST_PROG)
                dout <= {~last_q[DATA_W-1], tog_nx, last_q[DATA_W-3:0]};
            else
                dout <= rdata;
        end
    end

    // R4: refusal flag never clears without reset
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);
    // R6: window counter never passes its limit while loading
    a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |-> (cnt < CNT_W'(LOAD_WIN)));
    // R7: page buffer untouched by loads during the program cycle
    a_r7_prog_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> $stable(valid_q));
    // R8: polling bit is inverted while busy
    a_r8_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && rd_on) |=> (dout[DATA_W-1] != last_q[DATA_W-1]));
    // R9: a held read access shows a steady status
    a_r9_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && $past(st == ST_PROG) && rd_on && !rd_new) |=> $stable(dout));
endmodule

// File: rtl/pgf_writer.sv
module pgf_writer #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 8,
    parameter int LOAD_WIN  = 20,
    parameter int PROG_CYC  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              page_err
);
    localparam int PAGE_BYTES = 1 << PAGE_BITS;
    localparam int PG_W       = ADDR_W - PAGE_BITS;

    logic                         ld_go, rd_on, rd_new, pg_go;
    logic [ADDR_W-1:0]            ld_addr;
    logic [DATA_W-1:0]            ld_data, rdata;
    logic [PG_W-1:0]              pg_sel;
    logic [PAGE_BYTES*DATA_W-1:0] pg_bytes;
    logic [PAGE_BYTES-1:0]        pg_valid;

    pgf_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .ld_go(ld_go), .ld_addr(ld_addr),
        .ld_data(ld_data), .rd_on(rd_on), .rd_new(rd_new)
    );

    pgf_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
              .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .ld_go(ld_go), .ld_addr(ld_addr),
        .ld_data(ld_data), .rd_on(rd_on), .rd_new(rd_new), .rdata(rdata),
        .pg_go(pg_go), .pg_sel(pg_sel), .pg_bytes(pg_bytes),
        .pg_valid(pg_valid), .dout(dout), .dout_en(dout_en),
        .page_err(page_err)
    );

    pgf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .raddr(addr), .rdata(rdata),
        .pg_go(pg_go), .pg_sel(pg_sel), .pg_bytes(pg_bytes),
        .pg_valid(pg_valid)
    );
endmodule

// File: tb/pgf_writer_tb.sv
module pgf_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int LW = 20;
    localparam int PC = 60;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, page_err;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0, live = 0;
    string tag = "R11";

    pgf_writer #(.ADDR_W(AW), .DATA_W(8), .PAGE_BITS(8), .LOAD_WIN(LW), .PROG_CYC(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .page_err(page_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [7:0] m_mem [DEPTH];
    int   m_buf [int];
    int   m_state = 0, m_cnt = 0, m_page = 0;
    logic [7:0] m_last = 0, e_dout = 0, m_dh = 0;
    logic [AW-1:0] m_ah = 0;
    bit   e_en = 0, e_err = 0, m_tog = 0, p_act = 0, p_rd = 0;

    always @(posedge clk) begin
        bit act, rd, go;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_buf.delete();
            m_state = 0; m_cnt = 0; e_en = 0; e_dout = 0; e_err = 0;
            m_tog = 0; p_act = 0; p_rd = 0;
        end else begin
            act = !ce_n && !we_n && oe_n;
            rd  = !ce_n && !oe_n && we_n;
            go  = p_act && !act && oe_n;
            e_en = rd;
            if (!rd) e_dout = 0;
            else if (m_state == 2) begin
                if (!p_rd) m_tog = !m_tog;
                e_dout = {~m_last[7], m_tog, m_last[5:0]};
            end else e_dout = m_mem[addr];
            case (m_state)
                0: if (go) begin
                    m_buf.delete(); m_buf[int'(m_ah[7:0])] = m_dh;
                    m_page = int'(m_ah[AW-1:8]); m_last = m_dh; m_cnt = 0; m_state = 1;
                end
                1: begin
                    if (go && int'(m_ah[AW-1:8]) != m_page) e_err = 1;
                    if (go && int'(m_ah[AW-1:8]) == m_page) begin
                        m_buf[int'(m_ah[7:0])] = m_dh; m_last = m_dh; m_cnt = 0;
                    end else if (m_cnt == LW - 1) begin
                        m_state = 2; m_cnt = 0; m_tog = 0;
                    end else m_cnt++;
                end
                default: if (m_cnt == PC - 1) begin
                    for (int b = 0; b < 256; b++)
                        m_mem[m_page*256 + b] = m_buf.exists(b) ? 8'(m_buf[b]) : 8'hFF;
                    m_state = 0; m_cnt = 0;
                end else m_cnt++;
            endcase
            if (act && !p_act) m_ah = addr;
            if (act) m_dh = din;
            p_act = act; p_rd = rd;
        end
    end

    task automatic chk(string t, logic [7:0] act_v, logic [7:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", t, act_v, exp_v, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            chk({tag, " dout_en"}, {7'b0, dout_en}, {7'b0, e_en});
            chk({tag, " dout"}, dout, e_dout);
            chk({tag, " page_err"}, {7'b0, page_err}, {7'b0, e_err});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe: first cycle shows a_first/d_junk, later cycles a_junk/d_final
    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = 8'h5A;
        @(negedge clk); addr = ~a; din = d;
        @(negedge clk); we_n = 1; din = 8'hC3;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [7:0] exp_v, string t);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk); chk({t, " read"}, dout, exp_v);
        ce_n = 1; oe_n = 1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3); rst_n = 1; live = 1;
        idle(1);
        tag = "R11"; chk("R11 page_err", {7'b0, page_err}, 8'h00);
        chk("R11 dout_en", {7'b0, dout_en}, 8'h00);
        rd(11'h005, 8'hFF, "R11 erased");

        tag = "R5";  // out-of-order loads, overwrite, R2 latch points, R3 split
        wr(11'h210, 8'hA5); idle(4);
        wr(11'h203, 8'h3C); idle(10);
        wr(11'h210, 8'h81);
        idle(LW + 3);
        tag = "R8";
        rd(11'h210, 8'h41, "R8/R9 first status");
        idle(1);
        rd(11'h210, 8'h01, "R9 second status");
        tag = "R7"; wr(11'h300, 8'h77);
        idle(PC);
        rd(11'h210, 8'h81, "R5 overwrite");
        rd(11'h203, 8'h3C, "R3 byte");
        rd(11'h2FF, 8'hFF, "R7 fill");
        rd(11'h300, 8'hFF, "R7 ignored load");

        tag = "R4";
        wr(11'h400, 8'h11); idle(2);
        wr(11'h512, 8'h22);
        idle(LW + PC + 4);
        rd(11'h400, 8'h11, "R4 kept");
        rd(11'h512, 8'hFF, "R4 refused");
        chk("R4 page_err", {7'b0, page_err}, 8'h01);

        tag = "R1";
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 11'h600; din = 8'h99;
        idle(3); ce_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk); ce_n = 0; we_n = 0; addr = 11'h601; din = 8'h98;
        idle(3); oe_n = 0; @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        idle(LW + PC + 4);
        rd(11'h600, 8'hFF, "R1 oe low");
        rd(11'h601, 8'hFF, "R1 oe abort");

        tag = "R6";
        wr(11'h700, 8'h55); idle(LW + 8);
        wr(11'h701, 8'h66);
        idle(PC + 4);
        rd(11'h700, 8'h55, "R6 first");
        rd(11'h701, 8'hFF, "R6 late");
        tag = "R10";
        idle(2);
        chk("R10 idle bus", dout, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule